// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block performs one integer operation per issue cycle on operands that are 8, 16 or 32 bits wide. A size input selects the width. It covers the adding and subtracting families, compare, increment and decrement, the bitwise logic operations, a flag-only AND test, one's complement and negation. Each operation produces a result, a write-enable for the destination and a six-bit status word. That word is held in a flag register inside the block. A policy that belongs to each opcode decides which flag bits the operation may change and whether it writes a result.

The host drives `issue_i` together with an opcode, a size and two operands for one cycle. On the next rising edge the block registers the result and the write-enable and updates the flag register. All three outputs therefore reflect the operation one cycle after issue. Add-with-carry and subtract-with-borrow read the carry bit already stored in the flag register, so wide values can be processed as a chain of narrower operations. The block has no state machine. Its only sequential state is the flag register, the result register and the write-enable register. The rules here use the same reset, naming and layout that a state-machine block would.

Top module: `flag_alu`

## Requirements
- R1: While `rst_n` is low and after reset, `flags_o`, `result_o` and `wr_en_o` are all zero.
- R2: The opcodes are 0 add, 1 add plus stored carry, 2 subtract, 3 subtract minus stored carry, 5 increment and 6 decrement. For these, `result_o` holds the wrapped sum or difference at the selected width one cycle after issue, and `wr_en_o` is high for that single cycle.
- R3: `flags_o` bits are [0] carry, [1] auxiliary carry, [2] sign, [3] zero, [4] parity and [5] overflow. Carry is the carry or borrow out of the top bit of the selected width. Auxiliary carry is the carry or borrow out of bit 3. Sign is the top result bit at that width. Zero means the result is zero over that width. Parity is 1 when the low 8 result bits hold an even number of ones. Overflow reports signed overflow.
- R4: Opcode 4 (compare) subtracts operand B from operand A and updates all six flags as subtract does. It leaves `wr_en_o` low and `result_o` unchanged.
- R5: Increment and decrement update every flag as add or subtract of one would, except carry, which keeps its previous value.
- R6: Opcodes 7 AND, 8 OR and 9 XOR write the bitwise result. They clear carry, overflow and auxiliary carry, and set sign, zero and parity from the result.
- R7: Opcode 10 (test) sets the flags exactly as AND would. It leaves `wr_en_o` low and `result_o` unchanged.
- R8: Opcode 11 writes the one's complement of operand A and leaves all six flags unchanged.
- R9: Opcode 12 writes zero minus operand A. Carry is set unless the operand is zero. Overflow is set only when the operand is the most negative value at that width.
- R10: Size 0 selects 8 bits, size 1 selects 16 bits, and sizes 2 and 3 select 32 bits. Operand bits above the selected width are ignored, and written result bits above it are zero.
- R11: A cycle with `issue_i` low, or an issue with an opcode from 13 to 15, keeps `wr_en_o` low and leaves `flags_o` and `result_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Starts one operation this cycle |
| opcode_i | input | 4 | Operation code (see R2 to R11) |
| size_i | input | 2 | Operand width select (see R10) |
| opa_i | input | DATA_W | Operand A (destination value) |
| opb_i | input | DATA_W | Operand B (source value) |
| result_o | output | DATA_W | Last written result, zero-extended |
| wr_en_o | output | 1 | Destination write strobe for the last issue |
| flags_o | output | 6 | Stored status word (see R3) |

## Verification
The bound properties assume that every input is a known value at each rising edge while `rst_n` is high. They also assume that a carry-chained operation reads the flag word the previous issue left behind, with no other writer in between. The bench drives all inputs at the falling edge and runs directed carry and borrow chains back to back. It then sweeps every opcode value, including the unused ones, across all four size codes with operands that carry junk above the selected width. Idle cycles are mixed in to exercise the hold paths.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int FLAG_W = 6;
    localparam int FL_CY  = 0;
    localparam int FL_AUX = 1;
    localparam int FL_SGN = 2;
    localparam int FL_ZER = 3;
    localparam int FL_PAR = 4;
    localparam int FL_OVF = 5;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_CMP  = 4'd4,
        OP_INC  = 4'd5,
        OP_DEC  = 4'd6,
        OP_AND  = 4'd7,
        OP_OR   = 4'd8,
        OP_XOR  = 4'd9,
        OP_TEST = 4'd10,
        OP_NOT  = 4'd11,
        OP_NEG  = 4'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } alu_size_e;

    typedef struct packed {
        logic [FLAG_W-1:0] upd;
        logic              wr;
    } alu_policy_t;

endpackage

// File: rtl/alu_policy.sv
module alu_policy
    import flag_alu_pkg::*;
(
    input  logic [3:0]  opcode_i,
    output alu_policy_t pol_o
);
    localparam logic [FLAG_W-1:0] ALL_FLAGS = '1;
    localparam logic [FLAG_W-1:0] NO_CARRY  = ALL_FLAGS & ~(FLAG_W'(1) << FL_CY);

    always_comb begin
        pol_o.upd = '0;
        pol_o.wr  = 1'b0;
        case (opcode_i)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_NEG,
            OP_AND, OP_OR, OP_XOR: begin
                pol_o.upd = ALL_FLAGS;
                pol_o.wr  = 1'b1;
            end
            OP_CMP, OP_TEST: begin
                pol_o.upd = ALL_FLAGS;
                pol_o.wr  = 1'b0;
            end
            OP_INC, OP_DEC: begin
                pol_o.upd = NO_CARRY;
                pol_o.wr  = 1'b1;
            end
            OP_NOT: begin
                pol_o.upd = '0;
                pol_o.wr  = 1'b1;
            end
            default: begin
                pol_o.upd = '0;
                pol_o.wr  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        opcode_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              cy_q_i,
    output logic [DATA_W-1:0] res_o,
    output logic [FLAG_W-1:0] flags_nxt_o
);
    localparam int EXT_W = DATA_W + 2;

    logic [DATA_W-1:0] wmask, a_m, b_m, x, y, arith_r, res;
    logic [EXT_W-1:0]  arith;
    logic              cin, is_sub, is_logic, cout, ovf, aux;
    logic              sx, sy, sr;

    always_comb begin
        unique case (size_i)
            SZ_BYTE: wmask = DATA_W'(8'hFF);
            SZ_HALF: wmask = DATA_W'(16'hFFFF);
            default: wmask = '1;
        endcase
        a_m = opa_i & wmask;
        b_m = opb_i & wmask;

        x        = a_m;
        y        = b_m;
        cin      = 1'b0;
        is_sub   = 1'b0;
        is_logic = 1'b0;
        case (opcode_i)
            OP_ADC:                 cin = cy_q_i;
            OP_SUB, OP_CMP:         is_sub = 1'b1;
            OP_SBB: begin           is_sub = 1'b1; cin = cy_q_i; end
            OP_INC:                 y = DATA_W'(1);
            OP_DEC: begin           is_sub = 1'b1; y = DATA_W'(1); end
            OP_NEG: begin           is_sub = 1'b1; x = '0; y = a_m; end
            OP_AND, OP_OR, OP_XOR, OP_TEST, OP_NOT: is_logic = 1'b1;
            default: ;
        endcase

        if (is_sub)
            arith = {2'b00, x} - {2'b00, y} - EXT_W'(cin);
        else
            arith = {2'b00, x} + {2'b00, y} + EXT_W'(cin);
        arith_r = arith[DATA_W-1:0] & wmask;

        unique case (size_i)
            SZ_BYTE: begin cout = arith[8];  sx = x[7];  sy = y[7];  sr = arith_r[7];  end
            SZ_HALF: begin cout = arith[16]; sx = x[15]; sy = y[15]; sr = arith_r[15]; end
            default: begin
                cout = arith[DATA_W];
                sx = x[DATA_W-1]; sy = y[DATA_W-1]; sr = arith_r[DATA_W-1];
            end
        endcase
        aux = x[4] ^ y[4] ^ arith[4];
        ovf = is_sub ? ((sx != sy) && (sr != sx)) : ((sx == sy) && (sr != sx));

        case (opcode_i)
            OP_AND, OP_TEST: res = a_m & b_m;
            OP_OR:           res = a_m | b_m;
            OP_XOR:          res = a_m ^ b_m;
            OP_NOT:          res = ~a_m & wmask;
            default:         res = arith_r;
        endcase

        res_o = res;
        flags_nxt_o[FL_CY]  = is_logic ? 1'b0 : cout;
        flags_nxt_o[FL_AUX] = is_logic ? 1'b0 : aux;
        flags_nxt_o[FL_OVF] = is_logic ? 1'b0 : ovf;
        flags_nxt_o[FL_ZER] = (res == '0);
        flags_nxt_o[FL_PAR] = ~^res[7:0];
        unique case (size_i)
            SZ_BYTE: flags_nxt_o[FL_SGN] = res[7];
            SZ_HALF: flags_nxt_o[FL_SGN] = res[15];
            default: flags_nxt_o[FL_SGN] = res[DATA_W-1];
        endcase
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import flag_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [FLAG_W-1:0] upd_i,
    input  logic [FLAG_W-1:0] nxt_i,
    output logic [FLAG_W-1:0] flags_q_o
);
    for (genvar gi = 0; gi < FLAG_W; gi++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags_q_o[gi] <= 1'b0;
            else if (issue_i && upd_i[gi])
                flags_q_o[gi] <= nxt_i[gi];
        end
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [3:0]        opcode_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [5:0]        flags_o
);
    alu_policy_t       pol;
    logic [DATA_W-1:0] res_c;
    logic [FLAG_W-1:0] flags_nxt, flags_q;

    alu_policy u_policy (
        .opcode_i (opcode_i),
        .pol_o    (pol)
    );

    alu_datapath #(.DATA_W(DATA_W)) u_dp (
        .opcode_i    (opcode_i),
        .size_i      (size_i),
        .opa_i       (opa_i),
        .opb_i       (opb_i),
        .cy_q_i      (flags_q[FL_CY]),
        .res_o       (res_c),
        .flags_nxt_o (flags_nxt)
    );

    alu_flag_reg u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_i   (issue_i),
        .upd_i     (pol.upd),
        .nxt_i     (flags_nxt),
        .flags_q_o (flags_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
            wr_en_o  <= 1'b0;
        end else begin
            wr_en_o <= issue_i && pol.wr;
            if (issue_i && pol.wr)
                result_o <= res_c;
        end
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/flag_alu_checker.sv
module flag_alu_checker
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_i,
    input logic [3:0]        opcode_i,
    input logic [1:0]        size_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] result_o,
    input logic              wr_en_o,
    input logic [5:0]        flags_o
);
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && opcode_i == OP_CMP |=> !wr_en_o && $stable(result_o)); // R4

    AST_INCDEC_CARRY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && (opcode_i == OP_INC || opcode_i == OP_DEC) |=> flags_o[FL_CY] == $past(flags_o[FL_CY])); // R5

    AST_LOGIC_CLEARS_CO: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && (opcode_i == OP_AND || opcode_i == OP_OR || opcode_i == OP_XOR) |=> !flags_o[FL_CY] && !flags_o[FL_OVF] && !flags_o[FL_AUX]); // R6

    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && opcode_i == OP_TEST |=> !wr_en_o && !flags_o[FL_CY] && !flags_o[FL_OVF]); // R7

    AST_NOT_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && opcode_i == OP_NOT |=> $stable(flags_o) && wr_en_o); // R8

    AST_NEG_ZERO_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && opcode_i == OP_NEG && size_i == SZ_BYTE && opa_i[7:0] == 8'h00 |=> !flags_o[FL_CY] && flags_o[FL_ZER]); // R9

    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && opcode_i == OP_ADD && size_i == SZ_BYTE |=> result_o[DATA_W-1:8] == '0); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> !wr_en_o && $stable(flags_o) && $stable(result_o)); // R11
endmodule

bind flag_alu flag_alu_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_i  (issue_i),
    .opcode_i (opcode_i),
    .size_i   (size_i),
    .opa_i    (opa_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .flags_o  (flags_o)
);

// File: tb/flag_alu_tb_top.sv
module flag_alu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [3:0]  opcode_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] opa_i = '0, opb_i = '0;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic [5:0]  flags_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [5:0]  ref_f   = '0;
    logic [31:0] ref_res = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_alu #(.DATA_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .opcode_i(opcode_i),
        .size_i(size_i), .opa_i(opa_i), .opb_i(opb_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural model: returns the written result, write strobe and next flags.
    task automatic model(input int op, input int sz, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] r, output logic we, output logic [5:0] nf);
        int w;
        int kind;
        logic [63:0] m, x, y, ci, s;
        logic cy, xs, ys, rs, ov;
        w  = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        m  = (64'd1 << w) - 64'd1;
        x  = {32'd0, a} & m;
        y  = {32'd0, b} & m;
        ci = 64'd0;
        nf = ref_f;
        we = 1'b0;
        r  = '0;
        kind = 0;
        case (op)
            0: kind = 1;
            1: begin kind = 1; ci = {63'd0, ref_f[0]}; end
            2, 4: kind = 2;
            3: begin kind = 2; ci = {63'd0, ref_f[0]}; end
            5: begin kind = 1; y = 64'd1; end
            6: begin kind = 2; y = 64'd1; end
            12: begin kind = 2; y = x; x = 64'd0; end
            7, 8, 9, 10: kind = 3;
            11: begin r = 32'(~x & m); we = 1'b1; end
            default: ;
        endcase
        if (kind == 1 || kind == 2) begin
            if (kind == 1) begin
                s  = x + y + ci;
                cy = s[w];
            end else begin
                s  = x - y - ci;
                cy = (x < y + ci);
            end
            s  = s & m;
            r  = 32'(s);
            xs = x[w-1]; ys = y[w-1]; rs = s[w-1];
            ov = (kind == 1) ? (xs == ys && rs != xs) : (xs != ys && rs != xs);
            if (op != 5 && op != 6) nf[0] = cy;
            nf[1] = x[4] ^ y[4] ^ s[4];
            nf[5] = ov;
            we = (op != 4);
        end else if (kind == 3) begin
            s = (op == 8) ? (x | y) : (op == 9) ? (x ^ y) : (x & y);
            r = 32'(s);
            nf[0] = 1'b0; nf[1] = 1'b0; nf[5] = 1'b0;
            we = (op != 10);
        end
        if (kind != 0) begin
            nf[2] = r[w-1];
            nf[3] = (r == 32'd0);
            nf[4] = ($countones(r[7:0]) % 2) == 0;
        end
    endtask

    task automatic run_op(input string req, input int op, input int sz,
                          input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        logic we;
        logic [5:0] nf;
        model(op, sz, a, b, r, we, nf);
        issue_i  = 1'b1;
        opcode_i = 4'(op);
        size_i   = 2'(sz);
        opa_i    = a;
        opb_i    = b;
        @(negedge clk);
        issue_i = 1'b0;
        ref_f = nf;
        if (we) ref_res = r;
        check(req, "wr_en", {31'd0, wr_en_o}, {31'd0, we});
        check(req, "result", result_o, ref_res);
        check(req, "flags", {26'd0, flags_o}, {26'd0, ref_f});
    endtask

    task automatic idle_cycle();
        issue_i  = 1'b0;
        opcode_i = 4'd0;
        opa_i    = 32'hFFFF_FFFF;
        opb_i    = 32'hFFFF_FFFF;
        @(negedge clk);
        check("R11", "idle wr_en", {31'd0, wr_en_o}, 32'd0);
        check("R11", "idle result", result_o, ref_res);
        check("R11", "idle flags", {26'd0, flags_o}, {26'd0, ref_f});
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset flags", {26'd0, flags_o}, 32'd0);
        check("R1", "reset result", result_o, 32'd0);
        check("R1", "reset wr_en", {31'd0, wr_en_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op("R2", 0, 0, 32'h0000_007F, 32'h0000_0001);  // signed overflow, aux carry
        run_op("R3", 0, 0, 32'h0000_00FF, 32'h0000_0001);  // zero with carry out
        run_op("R2", 0, 2, 32'hFFFF_FFFF, 32'h0000_0001);  // low word carries
        run_op("R2", 1, 2, 32'h0000_0000, 32'h0000_0000);  // stored carry added
        run_op("R2", 2, 1, 32'h0000_0000, 32'h0000_0001);  // borrow out
        run_op("R2", 3, 1, 32'h0000_0005, 32'h0000_0002);  // stored borrow subtracted
        run_op("R4", 4, 0, 32'h0000_0010, 32'h0000_0020);
        run_op("R5", 0, 0, 32'h0000_0080, 32'h0000_0080);  // set carry
        run_op("R5", 5, 0, 32'h0000_00FF, 32'h0);          // inc wraps, carry kept
        run_op("R5", 6, 2, 32'h0000_0000, 32'h0);          // dec wraps, carry kept
        run_op("R6", 7, 1, 32'hABCD_F0F0, 32'h1234_0FF0);
        run_op("R6", 8, 0, 32'h0000_0000, 32'h0000_0000);
        run_op("R6", 9, 2, 32'h8000_0001, 32'h0000_0001);
        run_op("R7", 10, 0, 32'h0000_00F0, 32'h0000_0080);
        run_op("R8", 0, 0, 32'h0000_0001, 32'h0000_00FF);  // flags nonzero first
        run_op("R8", 11, 1, 32'h0000_1234, 32'h0);
        run_op("R9", 12, 0, 32'h0000_0000, 32'h0);
        run_op("R9", 12, 0, 32'h0000_0080, 32'h0);
        run_op("R9", 12, 1, 32'h0000_0001, 32'h0);
        run_op("R10", 0, 0, 32'hDEAD_BE10, 32'hCAFE_0120);
        run_op("R10", 2, 3, 32'h0000_0000, 32'h0000_0001);
        run_op("R11", 13, 0, 32'h1, 32'h1);
        run_op("R11", 15, 2, 32'h1, 32'h1);
        idle_cycle();

        for (int i = 0; i < 2000; i++) begin
            run_op("R3", int'($urandom_range(15, 0)), int'($urandom_range(3, 0)),
                   $urandom(), $urandom());
            if (i % 37 == 0) idle_cycle();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule